// File: doc/BRIEF.md
# Serial EEPROM Word Write Sequencer

This block carries out one complete 16-bit word write to a three-wire serial EEPROM. The EEPROM has a select line, a clock line, a data line into the device and a data line out of it. A host puts a word address and a data word on the inputs and pulses a start request. The block then shifts out the write opcode, the address and the data, releases select, and raises select again to poll the device's ready level on its data-out line. The poll runs for a bounded number of attempts.

After the poll, the block always sends a write-disable command, so the device is left protected. It then reports completion with a one-cycle done pulse and a timeout flag. The timeout flag shows whether the device never signalled ready.

Serial clock timing comes from a divider tick. The host sets the divider so that one tick lasts at least the minimum clock high or low time of the device, at whatever system clock frequency is in use.

Top module: `ee_wr_seq`

## Requirements
- R1: The write frame has `3 + ADDR_W + 16` serial clocks. It carries opcode `101` (binary), then the address, then the data. Each field is sent most significant bit first, and the device captures data-in on the rising serial clock.
- R2: The serial clock rises only while select is high. Each clock high phase lasts exactly `div_i + 1` system cycles. Data-in does not change while the serial clock is high.
- R3: After the last data bit, select goes low for one tick and then high again for the ready poll. No serial clock is issued during the poll.
- R4: The poll ends on the first attempt that sees a high level on the synchronized data-out line. In that case `timeout_o` reads 0 after the transaction.
- R5: A device that never becomes ready is polled `POLL_MAX` times, with the attempts spaced `POLL_GAP` ticks apart. Select then stays high for exactly `POLL_MAX * POLL_GAP * (div_i + 1)` cycles during the poll, and `timeout_o` reads 1 afterwards.
- R6: After the poll, select goes low for one tick. The block then sends a write-disable frame of `3 + ADDR_W` clocks: opcode `100` (binary) followed by an all-zero address.
- R7: `busy_o` is high from the cycle after an accepted start until `done_o` pulses. `done_o` is high for exactly one cycle, with `busy_o` already low. `timeout_o` holds its value until the next accepted start.
- R8: A start request that arrives while `busy_o` is high is ignored. The serial frames and the single done pulse of the transaction in flight are unchanged.
- R9: During reset, select, serial clock, data-in, `busy_o`, `done_o` and `timeout_o` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_i | input | DIV_W | Tick divider: one tick every `div_i + 1` cycles |
| start_i | input | 1 | Start request, accepted only while idle |
| addr_i | input | ADDR_W | Word address to write |
| data_i | input | 16 | Data word to write |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | Last transaction ran out of poll attempts |
| ee_cs_o | output | 1 | EEPROM select |
| ee_sk_o | output | 1 | EEPROM serial clock |
| ee_di_o | output | 1 | Serial data to the EEPROM |
| ee_do_i | input | 1 | Serial data / ready level from the EEPROM |

## Verification
The hardest case to reach from the ports is the exhausted poll, where the device stays busy through every attempt. The bench also has to show that the poll window has the exact length the bound gives. It reaches this case by holding the modelled data-out line low for the whole transaction, and it counts the system cycles in which select is high between the write frame and the disable frame. Ready devices are modelled by raising data-out a chosen number of cycles into the poll. A second start is injected in the middle of a transaction to show that it has no effect on the captured frames.

// File: rtl/ee_wr_pkg.sv
package ee_wr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WR, ST_GAP1, ST_POLL, ST_GAP2, ST_DIS, ST_END
  } seq_st_e;

  localparam logic [2:0] OP_WRITE = 3'b101;
  localparam logic [2:0] OP_WDIS  = 3'b100;
  localparam int         DATA_W   = 16;

  // serial clocks in the write frame
  function automatic int wr_frame_len(input int aw);
    return 3 + aw + DATA_W;
  endfunction

  // serial clocks in the write-disable frame
  function automatic int dis_frame_len(input int aw);
    return 3 + aw;
  endfunction

  // system cycles of an exhausted poll
  function automatic int poll_cycles(input int max_att, input int gap, input int div);
    return max_att * gap * (div + 1);
  endfunction
endpackage

// File: rtl/ee_tick_gen.sv
module ee_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == div_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!en_i || tick_o)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ee_sync2.sv
module ee_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/ee_wr_seq.sv
module ee_wr_seq
  import ee_wr_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int DIV_W    = 8,
  parameter int POLL_MAX = 1000,
  parameter int POLL_GAP = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o,
  output logic              ee_cs_o,
  output logic              ee_sk_o,
  output logic              ee_di_o,
  input  logic              ee_do_i
);
  localparam int FRAME_W = wr_frame_len(ADDR_W);
  localparam int DIS_W   = dis_frame_len(ADDR_W);
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam int ATT_W   = $clog2(POLL_MAX + 1);
  localparam int GAP_W   = $clog2(POLL_GAP + 1);

  seq_st_e            st_q;
  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   left_q;
  logic [1:0]         phase_q;
  logic [ATT_W-1:0]   att_q;
  logic [GAP_W-1:0]   gap_q;
  logic               tick, do_s;

  ee_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .en_i(busy_o), .div_i(div_i), .tick_o(tick)
  );

  ee_sync2 u_sync (.clk(clk), .rst_n(rst_n), .d_i(ee_do_i), .q_o(do_s));

  // named internal events
  logic shifting, bit_done, last_bit, poll_sample, poll_ok, poll_giveup;
  assign shifting    = (st_q == ST_WR) || (st_q == ST_DIS);
  assign bit_done    = shifting && tick && (phase_q == 2'd2);
  assign last_bit    = bit_done && (left_q == CNT_W'(1));
  assign poll_sample = (st_q == ST_POLL) && tick && (gap_q == GAP_W'(POLL_GAP - 1));
  assign poll_ok     = poll_sample && do_s;
  assign poll_giveup = poll_sample && !do_s && (att_q == ATT_W'(POLL_MAX - 1));

  assign busy_o  = (st_q != ST_IDLE);
  assign ee_cs_o = shifting || (st_q == ST_POLL);
  assign ee_sk_o = shifting && (phase_q == 2'd1);
  assign ee_di_o = shifting && sh_q[FRAME_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      sh_q      <= '0;
      left_q    <= '0;
      phase_q   <= '0;
      att_q     <= '0;
      gap_q     <= '0;
      done_o    <= 1'b0;
      timeout_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          sh_q      <= {OP_WRITE, addr_i, data_i};
          left_q    <= CNT_W'(FRAME_W);
          phase_q   <= 2'd0;
          timeout_o <= 1'b0;
          st_q      <= ST_WR;
        end
        ST_WR, ST_DIS: if (tick) begin
          if (phase_q == 2'd2) begin
            phase_q <= 2'd0;
            if (last_bit) begin
              st_q <= (st_q == ST_WR) ? ST_GAP1 : ST_END;
            end else begin
              sh_q   <= sh_q << 1;
              left_q <= left_q - 1'b1;
            end
          end else begin
            phase_q <= phase_q + 1'b1;
          end
        end
        ST_GAP1: if (tick) begin
          att_q <= '0;
          gap_q <= '0;
          st_q  <= ST_POLL;
        end
        ST_POLL: if (tick) begin
          if (poll_sample) begin
            gap_q <= '0;
            if (poll_ok) begin
              st_q <= ST_GAP2;
            end else if (poll_giveup) begin
              timeout_o <= 1'b1;
              st_q      <= ST_GAP2;
            end else begin
              att_q <= att_q + 1'b1;
            end
          end else begin
            gap_q <= gap_q + 1'b1;
          end
        end
        ST_GAP2: if (tick) begin
          sh_q    <= {OP_WDIS, {(ADDR_W + DATA_W){1'b0}}};
          left_q  <= CNT_W'(DIS_W);
          phase_q <= 2'd0;
          st_q    <= ST_DIS;
        end
        ST_END: if (tick) begin
          done_o <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // assertions beside the logic
  assert_sk_needs_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sk_o |-> ee_cs_o);
  assert_di_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_sk_o && $past(ee_sk_o)) |-> $stable(ee_di_o));
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_poll_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_POLL) |-> (att_q < ATT_W'(POLL_MAX)));
  assert_timeout_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_o) |-> $past(poll_giveup));
  assert_ready_ends_poll_R4: assert property (@(posedge clk) disable iff (!rst_n)
    poll_ok |=> (st_q == ST_GAP2) && !timeout_o);
endmodule

// File: tb/ee_wr_seq_tb_top.sv
module ee_wr_seq_tb_top;
  import ee_wr_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DW = 4;
  localparam int PMAX = 20;
  localparam int PGAP = 3;
  localparam int FW = 3 + AW + 16;
  localparam int DISW = 3 + AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [DW-1:0] div = '0;
  logic start = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0] data = '0;
  logic ee_do = 1'b0;
  logic busy, done, tmo, cs, sk, di;

  always #(CLK_PERIOD/2) clk = ~clk;

  ee_wr_seq #(.ADDR_W(AW), .DIV_W(DW), .POLL_MAX(PMAX), .POLL_GAP(PGAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .div_i(div), .start_i(start), .addr_i(addr),
    .data_i(data), .busy_o(busy), .done_o(done), .timeout_o(tmo),
    .ee_cs_o(cs), .ee_sk_o(sk), .ee_di_o(di), .ee_do_i(ee_do));

  int checks = 0, fails = 0;
  int sess = 0;
  logic [63:0] cap [0:2];
  int nb [0:2];
  int cshi [0:2];
  int skrun = 0, sk_bad = 0, ndone = 0, busy_drop = 0;
  logic prev_sk = 1'b0, prev_di = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // EEPROM-side model: capture bits on rising serial clock
  always @(posedge sk) if (cs && sess < 3) begin
    cap[sess] = {cap[sess][62:0], di};
    nb[sess]  = nb[sess] + 1;
  end
  always @(negedge cs) sess = sess + 1;

  always @(negedge clk) begin
    if (cs && sess < 3) cshi[sess] = cshi[sess] + 1;
    if (sk) skrun++;
    else if (skrun != 0) begin
      if (skrun != int'(div) + 1) sk_bad++;
      skrun = 0;
    end
    if (sk && prev_sk && di != prev_di) sk_bad++;
    prev_sk = sk;
    prev_di = di;
  end

  task automatic run(input logic [AW-1:0] a, input logic [15:0] d, input int dv,
                     input int rdy_dly, input bit inject);
    longint exp_frame;
    int lim;
    bit seen;
    div = DW'(dv);
    for (int i = 0; i < 3; i++) begin cap[i] = '0; nb[i] = 0; cshi[i] = 0; end
    sess = 0; sk_bad = 0; ndone = 0; busy_drop = 0; ee_do = 1'b0;
    @(negedge clk); start = 1'b1; addr = a; data = d;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R7 busy after start", busy, 1);
    fork
      begin
        if (inject) begin
          repeat (20) @(negedge clk);
          start = 1'b1; addr = ~a; data = ~d;
          @(negedge clk); start = 1'b0;
        end
      end
      begin
        if (rdy_dly >= 0) begin
          wait (sess == 1 && cs);
          repeat (rdy_dly) @(negedge clk);
          ee_do = 1'b1;
          wait (sess >= 2);
          ee_do = 1'b0;
        end
      end
      begin
        lim = 0; seen = 0;
        while (!seen && lim < 20000) begin
          @(negedge clk);
          if (done) begin seen = 1; ndone++; end
          else if (!busy) busy_drop++;
          lim++;
        end
        chk(seen, "R7 done reached", seen, 1);
      end
    join
    repeat (4) begin
      @(negedge clk);
      if (done) ndone++;
    end
    exp_frame = longint'({3'b101, a, d});
    chk(nb[0] == FW, "R1 write clock count", nb[0], FW);
    chk(cap[0][FW-1:0] == exp_frame[FW-1:0], inject ? "R8 frame unchanged" : "R1 write frame",
        longint'(cap[0][FW-1:0]), exp_frame);
    chk(sk_bad == 0, "R2 clock high time / data hold", sk_bad, 0);
    chk(nb[1] == 0, "R3 no clock in poll", nb[1], 0);
    chk(nb[2] == DISW, "R6 disable clock count", nb[2], DISW);
    chk(cap[2][DISW-1:0] == longint'({3'b100, {AW{1'b0}}}), "R6 disable frame",
        longint'(cap[2][DISW-1:0]), longint'({3'b100, {AW{1'b0}}}));
    if (rdy_dly < 0) begin
      chk(tmo == 1'b1, "R5 timeout flag", tmo, 1);
      chk(cshi[1] == poll_cycles(PMAX, PGAP, dv), "R5 poll window", cshi[1],
          poll_cycles(PMAX, PGAP, dv));
    end else begin
      chk(tmo == 1'b0, "R4 ready no timeout", tmo, 0);
      chk(cshi[1] < poll_cycles(PMAX, PGAP, dv), "R4 poll ends early", cshi[1],
          poll_cycles(PMAX, PGAP, dv));
    end
    chk(ndone == 1 && busy_drop == 0, inject ? "R8 single done" : "R7 done pulse",
        ndone * 100 + busy_drop, 100);
    chk(sess == 3 && !busy, "R7 idle after done", sess, 3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({cs, sk, di, busy, done, tmo} == 6'b0, "R9 reset outputs", {cs, sk, di, busy, done, tmo}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({cs, sk, di, busy, done, tmo} == 6'b0, "R9 idle after reset", {cs, sk, di, busy, done, tmo}, 0);
    foreach (cap[i]) cap[i] = '0;
    for (int dv = 0; dv < 4; dv += (dv == 0) ? 1 : 2) begin
      for (int k = 0; k < 4; k++) begin
        logic [AW-1:0] a;
        logic [15:0] d;
        a = (k == 0) ? '0 : (k == 3) ? '1 : AW'(k * 13 + dv);
        d = (k == 0) ? 16'hFFFF : (k == 3) ? 16'h0000 : 16'hA5C3 ^ 16'(k * 16'h1111 + dv);
        run(a, d, dv, (k % 3 == 0) ? -1 : k * 2 + dv, k == 1);
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule